// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Protocol Engine

This block is the bus-facing controller of a 4 KB serial memory attached to a two-wire open-drain bus. The bus clock and data lines are oversampled by the system clock. The block recognises bus start and stop conditions. It decodes the leading control byte against a fixed device-type code and three strap-selected select bits, and answers with acknowledges by enabling a low drive on the data line. It loads a 12-bit word pointer from two address bytes. It hands received write bytes to the page write engine and serves read bytes from the memory array.

Writes stream bytes into the current page. Only the low five pointer bits advance, so a long burst overwrites the start of the page. A stop after at least one data byte raises a one-cycle commit request, and the engine then reports itself busy. While busy, the block acknowledges nothing. Reads return the byte at the pointer. The full 12-bit pointer advances after every byte sent, and the master's acknowledge decides whether another byte follows.

The state machine has these states: IDLE, CTRL (control byte), ADDR_HI, ADDR_LO, WDATA, ACK_LEAD (waiting for the falling clock edge that opens the acknowledge slot), ACK_HOLD (driving the acknowledge), RD_BYTE, RD_MACK (releasing the line for the master's acknowledge), RD_SAMP (sampling that acknowledge), RD_LOAD (fetching the next byte) and WAIT_STOP. A start moves any state to CTRL, and a stop moves any state to IDLE. The other transitions are:
- CTRL goes to ACK_LEAD on a matching byte and to IDLE otherwise.
- Each received byte goes to ACK_LEAD, and ACK_LEAD goes to ACK_HOLD.
- ACK_HOLD goes to ADDR_HI, ADDR_LO, WDATA or RD_BYTE according to the byte just taken.
- RD_BYTE goes to RD_MACK, and RD_MACK goes to RD_SAMP.
- RD_SAMP goes to RD_LOAD on an acknowledge and to WAIT_STOP without one.
- RD_LOAD goes to RD_BYTE.

Top module: `eeprom_2w_slave`

## Requirements
- R1: After reset, and after any stop, the data line is released. A falling data line while the clock is high (start) aborts any transfer and begins a new control byte. A rising data line while the clock is high (stop) ends the transfer.
- R2: A control byte whose bits 7..4 equal 1010 and whose bits 3..1 equal `sel_strap` is acknowledged by driving the data line low through the high phase of the ninth clock. Bit 0 selects the operation: 1 is a read and 0 is a write. Bits arrive MSB first.
- R3: A control byte with a wrong type code or wrong select bits gets no acknowledge. The block then drives nothing and writes nothing until the next start.
- R4: While `wr_busy` is high, a control byte gets no acknowledge.
- R5: After a write control byte, the high address byte and then the low address byte set the pointer. Bits 7..4 of the high byte are ignored. Each data byte is acknowledged and produces one `wr_en` pulse carrying the pointer and the byte.
- R6: During a write, only pointer bits 4..0 advance, and they wrap within the 32-byte page. The 33rd byte of a burst therefore carries the address of the first byte.
- R7: A stop that follows at least one data byte produces exactly one `wr_commit` pulse. A stop after an address-only header produces none.
- R8: A read control byte with no address header returns the byte at the pointer left by the previous access, which is the last accessed address plus one.
- R9: An address header followed by a repeated start and a read control byte returns the byte at the header address.
- R10: A master acknowledge after a read byte makes the block send the next byte. A missing acknowledge makes it release the line and ignore clocks until a stop or start.
- R11: The read pointer wraps from 0xFFF to 0x000.
- R12: Read bits are changed only after falling clock edges, MSB first. The line is released during the master's acknowledge slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | When high, the data line is pulled low |
| sel_strap | input | 3 | Strap levels matched against the control byte select bits |
| wr_busy | input | 1 | Page write engine is programming |
| mem_addr | output | ADDR_W | Pointer presented to the memory array for reads |
| mem_rdata | input | 8 | Array data at `mem_addr` |
| wr_en | output | 1 | One-cycle strobe for a received write byte |
| wr_addr | output | ADDR_W | Address of the strobed byte |
| wr_data | output | 8 | Strobed byte |
| wr_commit | output | 1 | One-cycle request to program the buffered page |

## Verification
The write strobe of a data byte and the page wrap of the pointer happen in the same clock. When the pointer sits at the last byte of a page, the strobe must carry the old address while the low five bits fold to zero. The bench provokes this twice. It starts a three-byte burst two bytes before a page end, and it sends a 33-byte burst from a page start. It judges the result from the logged strobe addresses: 0x31F must be followed by 0x300, and the 33rd strobe must repeat 0x040.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CTRL,
        S_ADDR_HI,
        S_ADDR_LO,
        S_WDATA,
        S_ACK_LEAD,
        S_ACK_HOLD,
        S_RD_BYTE,
        S_RD_MACK,
        S_RD_SAMP,
        S_RD_LOAD,
        S_WAIT_STOP
    } tw_state_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/tw_bus_cond.sv
module tw_bus_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_lvl,
    output logic start_det,
    output logic stop_det
);

    logic scl_s, sda_s, scl_q, sda_q;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        logic scl_r, sda_r;
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_r <= 1'b1;
                    sda_r <= 1'b1;
                end else begin
                    scl_r <= scl_i;
                    sda_r <= sda_i;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_r <= 1'b1;
                    sda_r <= 1'b1;
                end else begin
                    scl_r <= g_sync[i-1].scl_r;
                    sda_r <= g_sync[i-1].sda_r;
                end
            end
        end
    end

    assign scl_s = g_sync[SYNC_STAGES-1].scl_r;
    assign sda_s = g_sync[SYNC_STAGES-1].sda_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign sda_lvl   = sda_s;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/tw_addr_ptr.sv
module tw_addr_ptr #(
    parameter int ADDR_W = 12,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step_page,
    input  logic              step_full,
    output logic [ADDR_W-1:0] ptr
);

    logic [ADDR_W-1:0] page_next;

    if (PAGE_W < ADDR_W) begin : g_paged
        assign page_next = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};

        a_r6_page_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
            (step_page && !load && !step_full)
                |=> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]))
            else $error("R6: page step changed upper pointer bits");
    end else begin : g_flat
        assign page_next = ptr + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ptr <= '0;
        else if (load)      ptr <= load_val;
        else if (step_full) ptr <= ptr + 1'b1;
        else if (step_page) ptr <= page_next;
    end

    a_r11_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step_full && !load && ptr == {ADDR_W{1'b1}}) |=> ptr == '0)
        else $error("R11: pointer did not wrap to zero");

endmodule

// File: rtl/eeprom_2w_slave.sv
module eeprom_2w_slave
    import tw_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int PAGE_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        sel_strap,
    input  logic              wr_busy,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit
);

    localparam int HI_W = ADDR_W - 8;

    tw_state_e st, nxt, ret_st;

    logic scl_rise, scl_fall, sda_lvl, start_det, stop_det;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sr;
    logic [6:0] tx_sr;
    logic [7:0] rx_byte;
    logic [HI_W-1:0] addr_hi;
    logic byte_done, ctrl_match, wrote_any;
    logic ptr_load, ptr_step_page, ptr_step_full;
    logic [ADDR_W-1:0] ptr;

    tw_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_lvl  (sda_lvl),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    assign rx_byte    = {rx_sr, sda_lvl};
    assign byte_done  = scl_rise && (bit_cnt == 3'd7);
    assign ctrl_match = (rx_byte[7:4] == DEV_TYPE) && (rx_byte[3:1] == sel_strap) && !wr_busy;

    assign ptr_load      = (st == S_ADDR_LO) && byte_done;
    assign ptr_step_page = (st == S_WDATA) && byte_done;
    assign ptr_step_full = (st == S_RD_BYTE) && byte_done;

    tw_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val ({addr_hi, rx_byte}),
        .step_page(ptr_step_page),
        .step_full(ptr_step_full),
        .ptr      (ptr)
    );

    assign mem_addr = ptr;

    // next-state logic
    always_comb begin
        nxt = st;
        if (start_det) begin
            nxt = S_CTRL;
        end else if (stop_det) begin
            nxt = S_IDLE;
        end else begin
            unique case (st)
                S_IDLE:      nxt = S_IDLE;
                S_CTRL:      if (byte_done) nxt = ctrl_match ? S_ACK_LEAD : S_IDLE;
                S_ADDR_HI,
                S_ADDR_LO,
                S_WDATA:     if (byte_done) nxt = S_ACK_LEAD;
                S_ACK_LEAD:  if (scl_fall) nxt = S_ACK_HOLD;
                S_ACK_HOLD:  if (scl_fall) nxt = ret_st;
                S_RD_BYTE:   if (byte_done) nxt = S_RD_MACK;
                S_RD_MACK:   if (scl_fall) nxt = S_RD_SAMP;
                S_RD_SAMP:   if (scl_rise) nxt = sda_lvl ? S_WAIT_STOP : S_RD_LOAD;
                S_RD_LOAD:   if (scl_fall) nxt = S_RD_BYTE;
                S_WAIT_STOP: nxt = S_WAIT_STOP;
                default:     nxt = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_st    <= S_IDLE;
            bit_cnt   <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            addr_hi   <= '0;
            wrote_any <= 1'b0;
            sda_oe    <= 1'b0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_commit <= 1'b0;
        end else begin
            wr_en     <= 1'b0;
            wr_commit <= 1'b0;
            if (start_det) begin
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                bit_cnt   <= '0;
                sda_oe    <= 1'b0;
                wr_commit <= wrote_any;
                wrote_any <= 1'b0;
            end else begin
                unique case (st)
                    S_CTRL, S_ADDR_HI, S_ADDR_LO, S_WDATA: begin
                        if (scl_rise) begin
                            rx_sr   <= rx_byte[6:0];
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == 3'd7) begin
                                if (st == S_CTRL) begin
                                    ret_st <= rx_byte[0] ? S_RD_BYTE : S_ADDR_HI;
                                end else if (st == S_ADDR_HI) begin
                                    addr_hi <= rx_byte[HI_W-1:0];
                                    ret_st  <= S_ADDR_LO;
                                end else if (st == S_ADDR_LO) begin
                                    ret_st <= S_WDATA;
                                end else begin
                                    wr_en     <= 1'b1;
                                    wr_addr   <= ptr;
                                    wr_data   <= rx_byte;
                                    wrote_any <= 1'b1;
                                    ret_st    <= S_WDATA;
                                end
                            end
                        end
                    end
                    S_ACK_LEAD: begin
                        if (scl_fall) sda_oe <= 1'b1;
                    end
                    S_ACK_HOLD: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (ret_st == S_RD_BYTE) begin
                                tx_sr  <= mem_rdata[6:0];
                                sda_oe <= ~mem_rdata[7];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    S_RD_BYTE: begin
                        if (scl_rise) bit_cnt <= bit_cnt + 3'd1;
                        if (scl_fall) begin
                            sda_oe <= ~tx_sr[6];
                            tx_sr  <= {tx_sr[5:0], 1'b1};
                        end
                    end
                    S_RD_MACK: begin
                        if (scl_fall) sda_oe <= 1'b0;
                    end
                    S_RD_LOAD: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            tx_sr   <= mem_rdata[6:0];
                            sda_oe  <= ~mem_rdata[7];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    a_r1_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st == S_CTRL) && !sda_oe)
        else $error("R1: start did not restart the control byte");

    a_r1_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st == S_IDLE) && !sda_oe)
        else $error("R1: stop did not return to idle");

    a_r2_ack_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ACK_LEAD && scl_fall && !start_det && !stop_det) |=> sda_oe)
        else $error("R2: acknowledge not driven");

    a_r4_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_CTRL && wr_busy) |=> st != S_ACK_LEAD)
        else $error("R4: control byte accepted while busy");

    a_r5_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(st) == S_WDATA)
        else $error("R5: write strobe outside data phase");

    a_r7_commit_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(stop_det))
        else $error("R7: commit without stop");

    a_r12_oe_on_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)))
        else $error("R12: data drive changed outside a falling clock edge");

endmodule

// File: tb/eeprom_2w_slave_bench.sv
module eeprom_2w_slave_bench;

    localparam int Q = 6;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] CW = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] CR = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic busy = 1'b0;
    logic sda_oe, wr_en, wr_commit;
    logic [11:0] mem_addr, wr_addr;
    logic [7:0] wr_data, mem_rdata;
    logic sda_bus;

    int n_chk = 0;
    int n_fail = 0;
    int wl_n = 0;
    int n_commit = 0;
    logic [11:0] wl_addr [64];
    logic [7:0]  wl_data [64];

    always #4 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    function automatic logic [7:0] pat(input logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5C;
    endfunction

    assign mem_rdata = pat(mem_addr);

    eeprom_2w_slave u_eeprom_2w_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .sel_strap(STRAP),
        .wr_busy  (busy),
        .mem_addr (mem_addr),
        .mem_rdata(mem_rdata),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_commit(wr_commit)
    );

    always @(posedge clk) begin
        if (wr_en && wl_n < 64) begin
            wl_addr[wl_n] <= wr_addr;
            wl_data[wl_n] <= wr_data;
        end
        if (wr_en) wl_n <= wl_n + 1;
        if (wr_commit) n_commit <= n_commit + 1;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic rx);
        m_sda = b;
        wait_q();
        m_scl = 1'b1;
        wait_q();
        rx = sda_bus;
        wait_q();
        m_scl = 1'b0;
        wait_q();
    endtask

    task automatic start_cond();
        m_sda = 1'b1;
        wait_q();
        m_scl = 1'b1;
        wait_q();
        m_sda = 1'b0;
        wait_q();
        m_scl = 1'b0;
        wait_q();
    endtask

    task automatic stop_cond();
        m_sda = 1'b0;
        wait_q();
        m_scl = 1'b1;
        wait_q();
        m_sda = 1'b1;
        wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
        clk_bit(1'b1, r);
        acked = !r;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d, output logic slot);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, r);
            d[i] = r;
        end
        clk_bit(!mack, r);
        slot = r;
    endtask

    task automatic header(input logic [7:0] hi, input logic [7:0] lo, output int acks);
        logic a;
        acks = 0;
        start_cond();
        send_byte(CW, a); acks += int'(a);
        send_byte(hi, a); acks += int'(a);
        send_byte(lo, a); acks += int'(a);
    endtask

    task automatic t_reset();
        chk(sda_oe == 1'b0, "R1 reset releases line", int'(sda_oe), 0);
        chk(wr_en == 1'b0 && wr_commit == 1'b0, "R1 reset strobes idle", int'({wr_en, wr_commit}), 0);
    endtask

    task automatic t_page_write();
        int acks, base, cbase;
        logic a;
        base = wl_n;
        cbase = n_commit;
        header(8'hF3, 8'h1E, acks);
        chk(acks == 3, "R2 control and address acknowledged", acks, 3);
        acks = 0;
        send_byte(8'h11, a); acks += int'(a);
        send_byte(8'h22, a); acks += int'(a);
        send_byte(8'h33, a); acks += int'(a);
        stop_cond();
        wait_q();
        chk(acks == 3, "R5 data bytes acknowledged", acks, 3);
        chk(wl_n - base == 3, "R5 one strobe per byte", wl_n - base, 3);
        chk(wl_addr[base] == 12'h31E && wl_data[base] == 8'h11, "R5 high nibble ignored",
            int'(wl_addr[base]), 'h31E);
        chk(wl_addr[base+1] == 12'h31F, "R5 second address", int'(wl_addr[base+1]), 'h31F);
        chk(wl_addr[base+2] == 12'h300 && wl_data[base+2] == 8'h33, "R6 page wrap",
            int'(wl_addr[base+2]), 'h300);
        chk(n_commit - cbase == 1, "R7 commit after data", n_commit - cbase, 1);
    endtask

    task automatic t_cur_read(input logic [11:0] exp_a, input string tag);
        logic a, s;
        logic [7:0] d;
        start_cond();
        send_byte(CR, a);
        recv_byte(1'b0, d, s);
        stop_cond();
        chk(a, {tag, " read acknowledged"}, int'(a), 1);
        chk(d == pat(exp_a), tag, int'(d), int'(pat(exp_a)));
    endtask

    task automatic t_random_read();
        int acks, cbase;
        logic a, s;
        logic [7:0] d;
        cbase = n_commit;
        header(8'h00, 8'hC3, acks);
        start_cond();
        send_byte(CR, a);
        recv_byte(1'b0, d, s);
        stop_cond();
        wait_q();
        chk(d == pat(12'h0C3), "R9 random read data", int'(d), int'(pat(12'h0C3)));
        chk(s == 1'b1, "R12 line released in master ack slot", int'(s), 1);
        chk(n_commit == cbase, "R7 no commit for header only", n_commit - cbase, 0);
    endtask

    task automatic t_seq_read();
        int acks;
        logic a, s, r;
        logic [7:0] d;
        logic [11:0] ea;
        int ones;
        header(8'h0F, 8'hFE, acks);
        start_cond();
        send_byte(CR, a);
        ea = 12'hFFE;
        for (int k = 0; k < 4; k++) begin
            recv_byte(k != 3, d, s);
            if (k == 2)
                chk(d == pat(12'h000), "R11 pointer wraps to zero", int'(d), int'(pat(12'h000)));
            else
                chk(d == pat(ea), "R10 sequential byte", int'(d), int'(pat(ea)));
            ea = ea + 12'd1;
        end
        ones = 0;
        for (int i = 0; i < 9; i++) begin
            clk_bit(1'b1, r);
            ones += int'(r);
        end
        chk(ones == 9, "R10 released after missing ack", ones, 9);
        stop_cond();
    endtask

    task automatic t_overflow();
        int acks, base;
        logic a;
        base = wl_n;
        header(8'h00, 8'h40, acks);
        for (int i = 0; i < 33; i++) send_byte(8'(i + 1), a);
        stop_cond();
        wait_q();
        chk(wl_n - base == 33, "R6 burst strobes", wl_n - base, 33);
        chk(wl_addr[base+31] == 12'h05F, "R6 last in page", int'(wl_addr[base+31]), 'h05F);
        chk(wl_addr[base+32] == 12'h040 && wl_data[base+32] == 8'd33, "R6 33rd overwrites first",
            int'(wl_addr[base+32]), 'h040);
    endtask

    task automatic t_mismatch();
        int base, cbase, acks;
        logic a;
        base = wl_n;
        cbase = n_commit;
        acks = 0;
        start_cond();
        send_byte({4'b1010, 3'b100, 1'b0}, a); acks += int'(a);
        send_byte(8'h00, a); acks += int'(a);
        send_byte(8'h00, a); acks += int'(a);
        send_byte(8'h5A, a); acks += int'(a);
        stop_cond();
        start_cond();
        send_byte({4'b1011, STRAP, 1'b0}, a); acks += int'(a);
        send_byte(8'h77, a); acks += int'(a);
        stop_cond();
        wait_q();
        chk(acks == 0, "R3 mismatch unanswered", acks, 0);
        chk(wl_n == base && n_commit == cbase, "R3 nothing written", wl_n - base, 0);
    endtask

    task automatic t_busy();
        logic a;
        busy = 1'b1;
        start_cond();
        send_byte(CW, a);
        stop_cond();
        chk(!a, "R4 no ack while busy", int'(a), 0);
        busy = 1'b0;
        start_cond();
        send_byte(CW, a);
        stop_cond();
        chk(a, "R4 ack after busy ends", int'(a), 1);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        report();
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_page_write();
        t_cur_read(12'h301, "R8 current address after write");
        t_random_read();
        t_seq_read();
        t_cur_read(12'h002, "R8 current address after read");
        t_overflow();
        t_mismatch();
        t_busy();
        repeat (10) @(negedge clk);
        report();
    end

endmodule